// File: doc/BRIEF.md
# Real-Time Clock Event Flag and Alarm Controller

This block holds the event and status logic of a real-time clock. A one-second strobe opens a short warning window. During this window a busy bit tells software that the time bytes are about to change. The window is followed by the update itself. When the update ends, the busy bit drops and an update-ended flag is raised. At the same moment the current hours, minutes and seconds are compared against three alarm bytes. An alarm byte whose two top bits are both 1 matches any value. A separate periodic strobe raises a periodic flag.

Each of the three flags has its own enable. When a raised flag meets a set enable, a sticky interrupt flag is raised and the interrupt line is pulled low. The line is open-drain: the block only drives it low, and otherwise leaves it released. Software reads the event status byte, and a read strobe clears all four flags. An update-inhibit input hides the busy bit and blocks the update-ended interrupt. Time keeping goes on while it is set.

All state changes on the rising clock edge. Reset is synchronous and active low. The default lead of 8 cycles matches a warning time of about 244 µs on a 32.768 kHz time base.

Top module: `rtc_event_ctrl`

## Requirements
- R1: After reset the status byte `evt_reg` is 8'h00, `irq_oe` is 0 and `stat_busy` is 0. The fields of `evt_reg` are: interrupt flag in bit 7, periodic flag in bit 6, alarm flag in bit 5, update-ended flag in bit 4. Bits 3 to 0 always read 0.
- R2: The interrupt flag (bit 7) is set on the edge where any of these pairs becomes true: periodic flag with `en_periodic`, alarm flag with `en_alarm`, or update-ended flag with `en_update` while `inhibit_xfer` is 0. A flag whose enable is 0 does not set it. `irq_oe` equals the interrupt flag, and 1 means the line is driven low.
- R3: When `rd_evt` is high on a clock edge, all four flags are cleared and `irq_oe` returns to 0 on that edge.
- R4: A flag event on the same edge as an `rd_evt` read is kept. That flag reads 1 after the edge, and the other flags read 0.
- R5: `stat_busy` rises on the edge that samples `sec_tick` and stays high for exactly LEAD_CYC+UPD_CYC cycles (9 by default). A `sec_tick` that arrives while the window is open is ignored.
- R6: On the edge where `stat_busy` falls, the update-ended flag (bit 4) is set.
- R7: While `inhibit_xfer` is 1, `stat_busy` reads 0. The update-ended flag is still set at the end of each update, but it does not set the interrupt flag, even when `en_update` is 1.
- R8: At the end of an update, the alarm flag (bit 5) is set when every alarm byte either equals its time byte or has bits 7:6 equal to 2'b11 (wildcard).
- R9: `per_tick` sets the periodic flag on the next edge whether or not `en_periodic` is set.
- R10: When a non-wildcard alarm byte differs from its time byte, the alarm flag stays 0 at the end of the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-second strobe that opens the warning window |
| per_tick | input | 1 | Periodic rate strobe |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| inhibit_xfer | input | 1 | Update transfer inhibit |
| rd_evt | input | 1 | Status byte read strobe |
| stat_busy | output | 1 | Update-in-progress bit |
| evt_reg | output | 8 | Event status byte |
| irq_oe | output | 1 | Drive the open-drain interrupt line low |

## Verification
If the sequencer counter is off by one, the falling edge of `stat_busy` and the rise of bit 4 of `evt_reg` move by a cycle. The bench sees this one cycle later, at the end of the first update window. A wrong compare bit, or a wrong wildcard decode, shows as a wrong bit 5 on the same edge that ends the update. A flag register that clears wrongly, or that drops an event arriving on a read, shows on the cycle right after the read. The interrupt line follows the sticky flag, so a wrong enable gate appears on `irq_oe` on the same edge the flag is raised.

// File: rtl/rtc_evt_pkg.sv
// Shared constants and helpers for the RTC event controller.
// Assumes time and alarm bytes of BYTE_W bits with a two-bit wildcard code on top.
package rtc_evt_pkg;
    localparam int BYTE_W   = 8;
    localparam int BIT_INTF = 7;
    localparam int BIT_PF   = 6;
    localparam int BIT_AF   = 5;
    localparam int BIT_UF   = 4;
    localparam logic [1:0] ALM_WILD = 2'b11;

    // True when an alarm byte accepts the given time byte
    function automatic logic byte_hit(input logic [BYTE_W-1:0] cur,
                                      input logic [BYTE_W-1:0] alm);
        return (alm[BYTE_W-1 -: 2] == ALM_WILD) || (cur == alm);
    endfunction
endpackage

// File: rtl/rtc_update_seq.sv
// Update window sequencer: a tick opens a window of LEAD_CYC+UPD_CYC cycles.
// busy is high for the whole window; upd_end marks the last cycle of it.
// Assumes ticks arriving while the window is open may be dropped.
module rtc_update_seq #(
    parameter int LEAD_CYC = 8,
    parameter int UPD_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic busy,
    output logic upd_end
);
    localparam int TOTAL = LEAD_CYC + UPD_CYC;
    localparam int CW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    logic [CW-1:0] cnt;

    assign upd_end = busy && (cnt == LAST);

    // Window counter: open on tick when idle, close after the last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (tick) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else if (upd_end) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: an idle tick opens the window on the next edge
    a_r5_tick_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !busy) |=> busy);
    // R6: the last cycle of the window closes it
    a_r6_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
        upd_end |=> !busy);
endmodule

// File: rtl/rtc_alarm_match.sv
// Alarm comparator for NFIELD time bytes packed low byte first.
// Each alarm byte with a wildcard top code is left out of the comparison.
module rtc_alarm_match #(
    parameter int NFIELD = 3
) (
    input  logic [NFIELD*rtc_evt_pkg::BYTE_W-1:0] cur_bytes,
    input  logic [NFIELD*rtc_evt_pkg::BYTE_W-1:0] alm_bytes,
    output logic                                  hit
);
    import rtc_evt_pkg::*;

    logic [NFIELD-1:0] field_ok;

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        assign field_ok[g] = byte_hit(cur_bytes[g*BYTE_W +: BYTE_W],
                                      alm_bytes[g*BYTE_W +: BYTE_W]);
    end

    assign hit = &field_ok;
endmodule

// File: rtl/rtc_flag_bank.sv
// Event flags plus the sticky interrupt flag.
// A read clears all flags; an event on the same edge as a read wins.
// Assumes en_upd already carries the inhibit gating.
module rtc_flag_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_per,
    input  logic ev_alm,
    input  logic ev_upd,
    input  logic rd,
    input  logic en_per,
    input  logic en_alm,
    input  logic en_upd,
    output logic pf,
    output logic af,
    output logic uf,
    output logic intf
);
    logic pf_n, af_n, uf_n, req_n;

    // Next flag values: keep unless read, always take a new event
    always_comb begin
        pf_n  = ev_per | (pf & ~rd);
        af_n  = ev_alm | (af & ~rd);
        uf_n  = ev_upd | (uf & ~rd);
        req_n = (pf_n & en_per) | (af_n & en_alm) | (uf_n & en_upd);
    end

    // Flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf   <= 1'b0;
            af   <= 1'b0;
            uf   <= 1'b0;
            intf <= 1'b0;
        end else begin
            pf   <= pf_n;
            af   <= af_n;
            uf   <= uf_n;
            intf <= req_n | (intf & ~rd);
        end
    end

    // R4: an event is never lost, even on a read edge
    a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ev_per |=> pf);
    // R3: a read with no new events empties every flag
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ev_per && !ev_alm && !ev_upd) |=> (!pf && !af && !uf && !intf));
    // R2: a rising interrupt flag has an enabled flag behind it
    a_r2_intf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intf) |-> ((pf && en_per) || (af && en_alm) || (uf && en_upd)));
endmodule

// File: rtl/rtc_event_ctrl.sv
// RTC event controller top: update window, alarm compare, flags, interrupt.
// The status byte reads intf/pf/af/uf in bits 7..4 and zero below.
// Assumes time bytes are stable when the update window ends.
module rtc_event_ctrl #(
    parameter int LEAD_CYC = 8,
    parameter int UPD_CYC  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       per_tick,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hr,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hr,
    input  logic       en_periodic,
    input  logic       en_alarm,
    input  logic       en_update,
    input  logic       inhibit_xfer,
    input  logic       rd_evt,
    output logic       stat_busy,
    output logic [7:0] evt_reg,
    output logic       irq_oe
);
    import rtc_evt_pkg::*;

    logic win_busy, win_end, alm_hit;
    logic pf, af, uf, intf;
    logic en_upd_eff;

    rtc_update_seq #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sec_tick),
        .busy   (win_busy),
        .upd_end(win_end)
    );

    rtc_alarm_match #(.NFIELD(3)) i_match (
        .cur_bytes({cur_hr, cur_min, cur_sec}),
        .alm_bytes({alm_hr, alm_min, alm_sec}),
        .hit      (alm_hit)
    );

    assign en_upd_eff = en_update & ~inhibit_xfer;

    rtc_flag_bank i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_per(per_tick),
        .ev_alm(win_end & alm_hit),
        .ev_upd(win_end),
        .rd    (rd_evt),
        .en_per(en_periodic),
        .en_alm(en_alarm),
        .en_upd(en_upd_eff),
        .pf    (pf),
        .af    (af),
        .uf    (uf),
        .intf  (intf)
    );

    // Status byte assembly and output drive
    always_comb begin
        evt_reg           = '0;
        evt_reg[BIT_INTF] = intf;
        evt_reg[BIT_PF]   = pf;
        evt_reg[BIT_AF]   = af;
        evt_reg[BIT_UF]   = uf;
    end
    assign stat_busy = win_busy & ~inhibit_xfer;
    assign irq_oe    = intf;

    // R8: the alarm flag only rises at the end of an update window
    a_r8_alarm_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> $past(win_end));
    // R6: the update-ended flag follows the close of the window
    a_r6_uf_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_busy) |-> uf);
endmodule

// File: tb/test_rtc_event_ctrl.sv
// Directed bench for rtc_event_ctrl; inputs driven and outputs sampled at negedge.
module test_rtc_event_ctrl;
    localparam int TOTAL = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 0, per_tick = 0, rd_evt = 0;
    logic [7:0] cur_sec = 8'h30, cur_min = 8'h15, cur_hr = 8'h07;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
    logic en_periodic = 0, en_alarm = 0, en_update = 0, inhibit_xfer = 0;
    logic stat_busy, irq_oe;
    logic [7:0] evt_reg;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_event_ctrl i_rtc_event_ctrl (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .per_tick(per_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
        .inhibit_xfer(inhibit_xfer), .rd_evt(rd_evt),
        .stat_busy(stat_busy), .evt_reg(evt_reg), .irq_oe(irq_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_evt();
        rd_evt = 1; cyc(1); rd_evt = 0;
    endtask

    // Tick, then wait until the window has closed
    task automatic run_update();
        sec_tick = 1; cyc(1); sec_tick = 0; cyc(TOTAL);
    endtask

    task automatic t_reset();
        rst_n = 0; cyc(3); rst_n = 1; cyc(1);
        chk("R1 evt_reg after reset", evt_reg, 8'h00);
        chk("R1 irq_oe after reset", irq_oe, 0);
        chk("R1 busy after reset", stat_busy, 0);
    endtask

    task automatic t_window();
        sec_tick = 1; cyc(1); sec_tick = 0;
        chk("R5 busy rises", stat_busy, 1);
        cyc(3); sec_tick = 1; cyc(1); sec_tick = 0;   // ignored second tick
        cyc(TOTAL - 5);
        chk("R5 busy at last cycle", stat_busy, 1);
        chk("R6 uf not yet", evt_reg[4], 0);
        cyc(1);
        chk("R5 busy falls on time", stat_busy, 0);
        chk("R6 uf set on close", evt_reg[4], 1);
        chk("R1 low nibble zero", evt_reg[3:0], 0);
        chk("R2 no intf without enable", evt_reg[7], 0);
        cyc(2);
        chk("R5 late tick ignored", stat_busy, 0);
        read_evt();
        chk("R3 read clears", evt_reg, 8'h00);
    endtask

    task automatic t_periodic();
        per_tick = 1; cyc(1); per_tick = 0;
        chk("R9 pf set with enable off", evt_reg, 8'h40);
        chk("R2 no irq without enable", irq_oe, 0);
        en_periodic = 1; per_tick = 1; cyc(1); per_tick = 0;
        chk("R2 intf and pf", evt_reg, 8'hC0);
        chk("R2 irq driven", irq_oe, 1);
        read_evt();
        chk("R3 read clears all", evt_reg, 8'h00);
        chk("R3 irq released", irq_oe, 0);
        en_periodic = 0;
    endtask

    task automatic t_collide();
        per_tick = 1; cyc(1); per_tick = 0;
        alm_hr = 8'hC0; alm_min = 8'hC0; alm_sec = 8'hC0;
        run_update();
        chk("R8 all wildcard", evt_reg, 8'h70);
        rd_evt = 1; per_tick = 1; cyc(1); rd_evt = 0; per_tick = 0;
        chk("R4 event on read kept", evt_reg, 8'h40);
        read_evt();
    endtask

    task automatic t_alarm();
        en_alarm = 1;
        alm_hr = 8'h07; alm_min = 8'h15; alm_sec = 8'h30;
        run_update();
        chk("R8 exact match", evt_reg, 8'hB0);
        chk("R8 irq from alarm", irq_oe, 1);
        read_evt();
        alm_hr = 8'hC5; alm_min = 8'hFF; alm_sec = 8'h30;
        run_update();
        chk("R8 hour and minute wildcard", evt_reg[5], 1);
        read_evt();
        alm_hr = 8'h07; alm_min = 8'h16; alm_sec = 8'h30;
        run_update();
        chk("R10 minute mismatch", evt_reg, 8'h10);
        read_evt();
        alm_hr = 8'h80; alm_min = 8'hC0; alm_sec = 8'hC0;
        run_update();
        chk("R10 top code 10 not wildcard", evt_reg[5], 0);
        read_evt();
        en_alarm = 0;
    endtask

    task automatic t_inhibit();
        en_update = 1; inhibit_xfer = 1;
        sec_tick = 1; cyc(1); sec_tick = 0;
        chk("R7 busy hidden", stat_busy, 0);
        cyc(TOTAL);
        chk("R7 uf still set, no intf", evt_reg, 8'h10);
        chk("R7 no irq", irq_oe, 0);
        read_evt();
        inhibit_xfer = 0;
        run_update();
        chk("R2 update irq", evt_reg, 8'h90);
        read_evt();
        en_update = 0;
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_window();
        t_periodic();
        t_collide();
        t_alarm();
        t_inhibit();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule